// File: doc/BRIEF.md
# Compact Instruction Length Decoder

This block sits at the front of the decode stage of a small word-addressed load-store core with eight 16-bit general registers. The core's instruction word is 16 bits wide. The block takes one base instruction word and splits it into a 4-bit opcode and two 6-bit operand codes: a destination and a source. It classifies each operand's addressing mode and extracts the register index or the inline literal it carries. From the two operands it works out how many extension words follow the base word, which gives a total length of one, two or three words.

An instruction that tries to write into a literal has no useful meaning. The block does not drop it silently. Instead it raises a trap flag, which the surrounding core can use as a software breakpoint or trap. Fetching the extension words and executing the instruction belong to other stages.

All results are registered. They appear one clock after the cycle in which the input strobe is high, and they hold while the strobe is low.

Top module: `cld_decoder`

## Requirements
- R1: The opcode output equals word bits 3:0. The destination operand code is taken from bits 9:4 and the source operand code from bits 15:10.
- R2: Each operand mode output uses this 3-bit encoding:
  - codes 0x00–0x07 give 0 (register direct);
  - codes 0x08–0x0F give 1 (register indirect);
  - codes 0x10–0x17 give 2 (register plus next-word offset);
  - code 0x1E gives 3 (indirect through next word);
  - code 0x1F gives 4 (next-word literal);
  - codes 0x20–0x3F give 5 (inline literal);
  - codes 0x18–0x1D give 6 (reserved).
- R3: For codes 0x00–0x17 the register index output equals code bits 2:0. For every other code it is 0.
- R4: For codes 0x20–0x3F the 5-bit literal output equals the code minus 0x20. For every other code it is 0.
- R5: The length output equals 1 plus the number of operands whose code is in 0x10–0x17, 0x1E or 0x1F. Its value is always 1 to 3.
- R6: The trap output is 1 in an output-valid cycle whose destination code is 0x1F or at least 0x20. It is 0 in every other cycle.
- R7: The output-valid signal is high exactly in the cycle after a cycle in which the input strobe is high. When it is high, all decoded fields reflect the word sampled with that strobe.
- R8: In the cycle after a low input strobe, the opcode, modes, register indices, literals and length hold their previous values, and the trap output is 0. This holds whatever the input word is.
- R9: A synchronous active-high reset clears output-valid, the trap output, the length, and every opcode, mode, register and literal output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe qualifying in_word |
| in_word | input | 16 | Base instruction word |
| out_valid | output | 1 | Decoded fields are fresh this cycle |
| opcode | output | 4 | Basic opcode |
| dst_mode | output | 3 | Destination addressing mode (R2 encoding) |
| dst_reg | output | 3 | Destination register index |
| dst_lit | output | 5 | Destination inline literal value |
| src_mode | output | 3 | Source addressing mode (R2 encoding) |
| src_reg | output | 3 | Source register index |
| src_lit | output | 5 | Source inline literal value |
| len | output | 2 | Instruction length in words |
| trap | output | 1 | Literal-destination trap event |

## Verification
Some properties are checked on every cycle by the assertions:
- the one-cycle valid latency and the opcode tracking the sampled word;
- the length staying within 1 to 3 and agreeing with the two reported modes;
- the trap being raised only in a valid cycle with a literal destination mode;
- literals reading zero outside inline mode;
- fields holding after a low strobe.

The exact mapping from every operand code to its mode, register index and literal value can only be shown by the bench's scenarios. So can the reset values and the trap firing on each literal destination code. The bench sweeps the whole 16-bit word space with interleaved idle cycles and compares against an arithmetic reference model.

// File: rtl/cld_pkg.sv
package cld_pkg;

    localparam int WORD_W  = 16;
    localparam int OPC_W   = 4;
    localparam int OPND_W  = 6;
    localparam int REG_W   = 3;
    localparam int LIT_W   = OPND_W - 1;
    localparam int N_OPND  = 2;
    localparam int LEN_W   = $clog2(N_OPND + 2);

    // Bit position of operand k inside the word (k=0 destination, k=1 source)
    localparam int OPND_LSB = OPC_W;

    typedef enum logic [2:0] {
        MD_REG   = 3'd0,
        MD_IND   = 3'd1,
        MD_OFS   = 3'd2,
        MD_NWIND = 3'd3,
        MD_NWLIT = 3'd4,
        MD_INLIT = 3'd5,
        MD_RSVD  = 3'd6
    } opnd_mode_e;

    typedef struct packed {
        opnd_mode_e        mode;
        logic [REG_W-1:0]  rix;
        logic [LIT_W-1:0]  lit;
        logic              ext;
        logic              is_lit;
    } opnd_dec_t;

    localparam opnd_dec_t OPND_CLEAR = '{mode: MD_REG, rix: '0, lit: '0, ext: 1'b0, is_lit: 1'b0};

    // Whether a mode consumes one extension word
    function automatic logic mode_needs_ext(opnd_mode_e m);
        return (m == MD_OFS) || (m == MD_NWIND) || (m == MD_NWLIT);
    endfunction

endpackage

// File: rtl/cld_operand_class.sv
module cld_operand_class
    import cld_pkg::*;
(
    input  logic [OPND_W-1:0] code,
    output opnd_dec_t         dec
);

    always_comb begin
        dec = OPND_CLEAR;
        if (code[OPND_W-1]) begin
            dec.mode   = MD_INLIT;
            dec.lit    = code[LIT_W-1:0];
            dec.is_lit = 1'b1;
        end else begin
            unique case (code[4:3])
                2'b00: begin
                    dec.mode = MD_REG;
                    dec.rix  = code[REG_W-1:0];
                end
                2'b01: begin
                    dec.mode = MD_IND;
                    dec.rix  = code[REG_W-1:0];
                end
                2'b10: begin
                    dec.mode = MD_OFS;
                    dec.rix  = code[REG_W-1:0];
                    dec.ext  = 1'b1;
                end
                default: begin
                    unique case (code[2:0])
                        3'd6: begin
                            dec.mode = MD_NWIND;
                            dec.ext  = 1'b1;
                        end
                        3'd7: begin
                            dec.mode   = MD_NWLIT;
                            dec.ext    = 1'b1;
                            dec.is_lit = 1'b1;
                        end
                        default: dec.mode = MD_RSVD;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/cld_len_calc.sv
module cld_len_calc
    import cld_pkg::*;
#(
    parameter int N = N_OPND,
    localparam int W = $clog2(N + 2)
) (
    input  logic [N-1:0] ext_flags,
    output logic [W-1:0] len
);

    always_comb begin
        len = W'(1);
        for (int k = 0; k < N; k++) begin
            len = len + W'(ext_flags[k]);
        end
    end

endmodule

// File: rtl/cld_decoder.sv
module cld_decoder
    import cld_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    output logic [OPC_W-1:0]   opcode,
    output logic [2:0]         dst_mode,
    output logic [REG_W-1:0]   dst_reg,
    output logic [LIT_W-1:0]   dst_lit,
    output logic [2:0]         src_mode,
    output logic [REG_W-1:0]   src_reg,
    output logic [LIT_W-1:0]   src_lit,
    output logic [LEN_W-1:0]   len,
    output logic               trap
);

    opnd_dec_t            dec   [N_OPND];
    logic [N_OPND-1:0]    ext_v;
    logic [LEN_W-1:0]     len_c;

    opnd_dec_t            dec_q [N_OPND];
    logic [OPC_W-1:0]     opc_q;
    logic [LEN_W-1:0]     len_q;
    logic                 vld_q;
    logic                 trap_q;

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        cld_operand_class u_cls (
            .code (in_word[OPND_LSB + k*OPND_W +: OPND_W]),
            .dec  (dec[k])
        );
        assign ext_v[k] = dec[k].ext;
    end

    cld_len_calc #(.N(N_OPND)) u_len (
        .ext_flags (ext_v),
        .len       (len_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            trap_q <= 1'b0;
            opc_q  <= '0;
            len_q  <= '0;
            for (int k = 0; k < N_OPND; k++) dec_q[k] <= OPND_CLEAR;
        end else begin
            vld_q  <= in_valid;
            trap_q <= in_valid && dec[0].is_lit;
            if (in_valid) begin
                opc_q <= in_word[OPC_W-1:0];
                len_q <= len_c;
                for (int k = 0; k < N_OPND; k++) dec_q[k] <= dec[k];
            end
        end
    end

    assign out_valid = vld_q;
    assign trap      = trap_q;
    assign opcode    = opc_q;
    assign len       = len_q;
    assign dst_mode  = dec_q[0].mode;
    assign dst_reg   = dec_q[0].rix;
    assign dst_lit   = dec_q[0].lit;
    assign src_mode  = dec_q[1].mode;
    assign src_reg   = dec_q[1].rix;
    assign src_lit   = dec_q[1].lit;

endmodule

// File: rtl/cld_decoder_chk.sv
module cld_decoder_chk
    import cld_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [WORD_W-1:0]  in_word,
    input logic               out_valid,
    input logic [OPC_W-1:0]   opcode,
    input logic [2:0]         dst_mode,
    input logic [REG_W-1:0]   dst_reg,
    input logic [LIT_W-1:0]   dst_lit,
    input logic [2:0]         src_mode,
    input logic [REG_W-1:0]   src_reg,
    input logic [LIT_W-1:0]   src_lit,
    input logic [LEN_W-1:0]   len,
    input logic               trap
);

    AST_OPC_TRACK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (opcode == $past(in_word[OPC_W-1:0]))); // R1

    AST_LIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dst_mode != MD_INLIT) |-> (dst_lit == '0)); // R4

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (len >= LEN_W'(1) && len <= LEN_W'(3))); // R5

    AST_LEN_MODES: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(len) == 1 + int'(mode_needs_ext(opnd_mode_e'(dst_mode)))
                                      + int'(mode_needs_ext(opnd_mode_e'(src_mode))))); // R5

    AST_TRAP_QUAL: assert property (@(posedge clk) disable iff (rst)
        trap |-> (out_valid && (dst_mode == MD_INLIT || dst_mode == MD_NWLIT))); // R6

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |->
            ($stable(opcode) && $stable(len) && $stable(dst_mode) && $stable(src_mode)
             && $stable(dst_reg) && $stable(src_reg) && !trap)); // R8

endmodule

bind cld_decoder cld_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .opcode    (opcode),
    .dst_mode  (dst_mode),
    .dst_reg   (dst_reg),
    .dst_lit   (dst_lit),
    .src_mode  (src_mode),
    .src_reg   (src_reg),
    .src_lit   (src_lit),
    .len       (len),
    .trap      (trap)
);

// File: tb/cld_decoder_tb.sv
module cld_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic [3:0]  opcode;
    logic [2:0]  dst_mode, src_mode;
    logic [2:0]  dst_reg, src_reg;
    logic [4:0]  dst_lit, src_lit;
    logic [1:0]  len;
    logic        trap;

    int n_vec = 0;
    int n_bad = 0;

    // expected state after the most recent rising edge
    int  e_valid = 0, e_trap = 0, e_opc = 0, e_len = 0;
    int  e_dm = 0, e_dr = 0, e_dl = 0, e_sm = 0, e_sr = 0, e_sl = 0;
    bit  e_from_rst = 1'b1;
    bit  e_hold = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cld_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .opcode(opcode),
        .dst_mode(dst_mode), .dst_reg(dst_reg), .dst_lit(dst_lit),
        .src_mode(src_mode), .src_reg(src_reg), .src_lit(src_lit),
        .len(len), .trap(trap)
    );

    // arithmetic reference for one operand code
    task automatic ref_opnd(input int c, output int mode, output int rix,
                            output int lit, output int ext, output int islit);
        mode = 6; rix = 0; lit = 0; ext = 0; islit = 0;
        if (c >= 32)       begin mode = 5; lit = c - 32; islit = 1; end
        else if (c < 8)    begin mode = 0; rix = c; end
        else if (c < 16)   begin mode = 1; rix = c - 8; end
        else if (c < 24)   begin mode = 2; rix = c - 16; ext = 1; end
        else if (c == 30)  begin mode = 3; ext = 1; end
        else if (c == 31)  begin mode = 4; ext = 1; islit = 1; end
    endtask

    task automatic cmp(input int act, input int exp, input string tag, input string what);
        string t;
        t = e_from_rst ? "R9" : (e_hold && what != "out_valid" ? "R8" : tag);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", t, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [15:0] w);
        int dm, dr, dl, dx, di, sm, sr, sl, sx, si;
        @(negedge clk);
        n_vec++;
        cmp(int'(opcode),   e_opc,   "R1", "opcode");
        cmp(int'(dst_mode), e_dm,    "R2", "dst_mode");
        cmp(int'(src_mode), e_sm,    "R2", "src_mode");
        cmp(int'(dst_reg),  e_dr,    "R3", "dst_reg");
        cmp(int'(src_reg),  e_sr,    "R3", "src_reg");
        cmp(int'(dst_lit),  e_dl,    "R4", "dst_lit");
        cmp(int'(src_lit),  e_sl,    "R4", "src_lit");
        cmp(int'(len),      e_len,   "R5", "len");
        cmp(int'(trap),     e_trap,  "R6", "trap");
        cmp(int'(out_valid),e_valid, "R7", "out_valid");
        rst = r; in_valid = v; in_word = w;
        if (r) begin
            e_from_rst = 1'b1; e_hold = 1'b0;
            e_valid = 0; e_trap = 0; e_opc = 0; e_len = 0;
            e_dm = 0; e_dr = 0; e_dl = 0; e_sm = 0; e_sr = 0; e_sl = 0;
        end else begin
            ref_opnd(int'(w[9:4]),   dm, dr, dl, dx, di);
            ref_opnd(int'(w[15:10]), sm, sr, sl, sx, si);
            e_from_rst = 1'b0;
            e_hold  = !v;
            e_valid = v ? 1 : 0;
            e_trap  = (v && di == 1) ? 1 : 0;
            if (v) begin
                e_opc = int'(w[3:0]); e_len = 1 + dx + sx;
                e_dm = dm; e_dr = dr; e_dl = dl;
                e_sm = sm; e_sr = sr; e_sl = sl;
            end
        end
    endtask

    function automatic logic [15:0] mk(input int src, input int dst, input int opc);
        return {src[5:0], dst[5:0], opc[3:0]};
    endfunction

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        // R9: reset state, even with a strobe present during reset
        step(1'b1, 1'b0, 16'h0000);
        step(1'b1, 1'b1, 16'hFFFF);
        step(1'b0, 1'b0, 16'h1234);
        // R1/R2/R3: register direct and indirect, length 1
        step(1'b0, 1'b1, mk(8'h03, 8'h0D, 5));
        // R5: offset plus next-word literal, length 3
        step(1'b0, 1'b1, mk(8'h1F, 8'h15, 9));
        // R6: inline literal destination traps; R4 literal value
        step(1'b0, 1'b1, mk(8'h3F, 8'h25, 2));
        // R6: next-word literal destination traps
        step(1'b0, 1'b1, mk(8'h1E, 8'h1F, 15));
        // R2: reserved codes, no extension
        step(1'b0, 1'b1, mk(8'h18, 8'h1D, 0));
        // R8: idle with a different word, fields hold, trap drops
        step(1'b0, 1'b1, mk(8'h20, 8'h20, 1));
        step(1'b0, 1'b0, 16'hFFFF);
        step(1'b0, 1'b0, 16'h0000);
        // R7: back-to-back strobes
        step(1'b0, 1'b1, mk(8'h10, 8'h1E, 7));
        step(1'b0, 1'b1, mk(8'h07, 8'h17, 8));
        // reset mid-stream, R9
        step(1'b1, 1'b1, mk(8'h3A, 8'h3A, 3));
        step(1'b0, 1'b0, 16'h0000);
        // full sweep of every word with interleaved idle cycles
        for (int w = 0; w < 65536; w++) begin
            step(1'b0, (w % 7) != 3, 16'(w));
        end
        step(1'b0, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 16'h0000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule